// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder

This block sits on the memory side of a synchronous DRAM link with two banks. On every rising clock edge it samples the active-low strobes (chip select, row strobe, column strobe, write enable), the clock enable and the address bus. It turns each sample into a decoded command and keeps track of whether each bank is open or closed. Commands that do not fit the current bank state, and strobe patterns that are reserved, produce an error pulse and leave the state untouched.

Address bits have different meanings for different commands. The top bit picks the bank. The next bit down asks for auto-close on a column access, or for a close of both banks on a precharge. The low bits are captured as the mode word when the mode is loaded. A column access with auto-close keeps the bank open for a number of cycles equal to the burst length held in the mode word, and then closes it.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While rst_ni is low, and after it, until the first decoded command: cmd_o=0, bank_o=0, auto_pre_o=0, err_o=0, bank_act_o=2'b00 and mode_o=0.
- R2: A sample taken at clock edge n drives the outputs from edge n onward, and it acts only if cke_i was high at edge n-1. Otherwise cmd_o=0 (none) and no state changes. The stored cke value is cleared by reset, so the first edge after reset always gives none.
- R3: With cs_ni high the code is 1 (deselect). With cs_ni low, the pattern {ras_ni,cas_ni,we_ni} selects the command: 000 mode load (3), 001 refresh (9), 010 precharge (5, or 6 for all banks), 011 activate (4), 100 write (7), 101 read (8), 111 no-op (2).
- R4: addr_i[11] selects the bank, with 1 giving index 1 and 0 giving index 0. bank_o reports this index for activate, precharge, read and write, and is 0 for every other command.
- R5: Activate is legal only when the selected bank is closed, and it sets that bank's bit in bank_act_o.
- R6: Precharge is always legal. With addr_i[10]=0 it closes only the selected bank. With addr_i[10]=1 it reports code 6 and closes both banks.
- R7: Read and write are legal only when the selected bank is open and not counting down to close. auto_pre_o then equals addr_i[10], and it is 0 for every other command.
- R8: Mode load and refresh are legal only when both banks are closed. A mode load also needs addr_i[8:7]=0, and it copies addr_i[9:0] to mode_o.
- R9: A reserved pattern ({ras_ni,cas_ni,we_ni}=110 with cs_ni low) or any command that breaks a legality rule gives cmd_o=15 and err_o=1 for that cycle, with bank_act_o and mode_o left as they were.
- R10: A read or write with auto-close clears its bank bit on the BL-th edge after the edge that accepted it. BL is 1, 2, 4 or 8 for mode_o[2:0] = 0, 1, 2 or any value of 3 or more. During the countdown, read, write and activate to that bank are illegal, and a precharge closes the bank at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 12 | Address bus |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 1 | Bank index of the command |
| auto_pre_o | output | 1 | Auto-close requested |
| err_o | output | 1 | Illegal or reserved command pulse |
| bank_act_o | output | 2 | Per-bank open flag |
| mode_o | output | 10 | Captured mode word |

## Verification
A wrong bank flag does not stay hidden. It shows on bank_act_o in the same cycle, and the next command to that bank gets the wrong legality: either a spurious code 15 or a missing one. A countdown that is off by one moves the falling edge of the bank bit by exactly one cycle. The model compares every output on every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int NUM_BANKS = 2;
  localparam int MODE_W    = 10;
  localparam int CNT_W     = 4;

  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_DESL    = 4'd1,
    CMD_NOP     = 4'd2,
    CMD_MRS     = 4'd3,
    CMD_ACT     = 4'd4,
    CMD_PRE     = 4'd5,
    CMD_PREALL  = 4'd6,
    CMD_WR      = 4'd7,
    CMD_RD      = 4'd8,
    CMD_REF     = 4'd9,
    CMD_ILLEGAL = 4'd15
  } cmd_e;
endpackage

// File: rtl/sdram_strobe_decode.sv
module sdram_strobe_decode
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK_BIT = 11,
  parameter int AP_BIT   = 10,
  parameter int RSV_LSB  = 7,
  parameter int RSV_MSB  = 8
) (
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              raw_cmd_o,
  output logic              bank_o,
  output logic              ap_o,
  output logic              mrs_ok_o
);
  assign bank_o   = addr_i[BANK_BIT];
  assign ap_o     = addr_i[AP_BIT];
  assign mrs_ok_o = ~|addr_i[RSV_MSB:RSV_LSB];

  always_comb begin
    if (cs_ni) begin
      raw_cmd_o = CMD_DESL;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  raw_cmd_o = CMD_MRS;
        3'b001:  raw_cmd_o = CMD_REF;
        3'b010:  raw_cmd_o = ap_o ? CMD_PREALL : CMD_PRE;
        3'b011:  raw_cmd_o = CMD_ACT;
        3'b100:  raw_cmd_o = CMD_WR;
        3'b101:  raw_cmd_o = CMD_RD;
        3'b111:  raw_cmd_o = CMD_NOP;
        default: raw_cmd_o = CMD_ILLEGAL;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int CNT_W  = 4,
  parameter int MAX_BL = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             ap_start_i,
  input  logic [CNT_W-1:0] bl_i,
  output logic             active_o,
  output logic             closing_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (close_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (open_i) begin
      active_q <= 1'b1;
    end else if (ap_start_i) begin
      cnt_q <= bl_i;
    end else if (cnt_q != '0) begin
      if (cnt_q == CNT_W'(1)) active_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign active_o  = active_q;
  assign closing_o = (cnt_q != '0);

  AST_TRK_OPEN_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |-> !active_q); // R5
  AST_TRK_AP_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_start_i |-> (active_q && cnt_q == '0)); // R7
  AST_TRK_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_BL)); // R10
  AST_TRK_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1)) |=> !active_q); // R10
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK_BIT = 11,
  parameter int AP_BIT   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [3:0]        cmd_o,
  output logic              bank_o,
  output logic              auto_pre_o,
  output logic              err_o,
  output logic [1:0]        bank_act_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int MAX_BL = 8;

  cmd_e raw_cmd, cmd_d, cmd_q;
  logic sel, ap, mrs_ok, legal, exec;
  logic cke_q, bank_q, ap_q, err_q;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  bl;
  logic [NUM_BANKS-1:0] act, closing, b_open, b_close, b_ap;

  sdram_strobe_decode #(
    .ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .AP_BIT(AP_BIT), .RSV_LSB(7), .RSV_MSB(8)
  ) i_dec (
    .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .addr_i(addr_i),
    .raw_cmd_o(raw_cmd), .bank_o(sel), .ap_o(ap), .mrs_ok_o(mrs_ok)
  );

  always_comb begin
    unique case (mode_q[2:0])
      3'd0:    bl = CNT_W'(1);
      3'd1:    bl = CNT_W'(2);
      3'd2:    bl = CNT_W'(4);
      default: bl = CNT_W'(MAX_BL);
    endcase
  end

  // legality against state before this edge
  always_comb begin
    unique case (raw_cmd)
      CMD_MRS:           legal = ~|act && mrs_ok;
      CMD_REF:           legal = ~|act;
      CMD_ACT:           legal = ~act[sel];
      CMD_RD, CMD_WR:    legal = act[sel] && !closing[sel];
      CMD_ILLEGAL:       legal = 1'b0;
      default:           legal = 1'b1;
    endcase
  end

  assign exec  = cke_q;
  assign cmd_d = !exec ? CMD_NONE : (legal ? raw_cmd : CMD_ILLEGAL);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign b_open[b]  = (cmd_d == CMD_ACT) && (sel == 1'(b));
    assign b_close[b] = (cmd_d == CMD_PREALL) || ((cmd_d == CMD_PRE) && (sel == 1'(b)));
    assign b_ap[b]    = ((cmd_d == CMD_RD) || (cmd_d == CMD_WR)) && ap && (sel == 1'(b));

    sdram_bank_tracker #(.CNT_W(CNT_W), .MAX_BL(MAX_BL)) i_trk (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .open_i(b_open[b]), .close_i(b_close[b]), .ap_start_i(b_ap[b]), .bl_i(bl),
      .active_o(act[b]), .closing_o(closing[b])
    );

    AST_OPEN_ONLY_BY_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bank_act_o[b]) |-> (cmd_o == CMD_ACT && bank_o == 1'(b))); // R5
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_NONE;
      bank_q <= 1'b0;
      ap_q   <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      cke_q  <= cke_i;
      cmd_q  <= cmd_d;
      err_q  <= (cmd_d == CMD_ILLEGAL);
      bank_q <= (cmd_d inside {CMD_ACT, CMD_PRE, CMD_RD, CMD_WR}) ? sel : 1'b0;
      ap_q   <= (cmd_d inside {CMD_RD, CMD_WR}) ? ap : 1'b0;
      if (cmd_d == CMD_MRS) mode_q <= addr_i[MODE_W-1:0];
    end
  end

  assign cmd_o      = cmd_q;
  assign bank_o     = bank_q;
  assign auto_pre_o = ap_q;
  assign err_o      = err_q;
  assign bank_act_o = act;
  assign mode_o     = mode_q;

  AST_CKE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NONE) |-> $past(cke_i, 2)); // R2
  AST_MRS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS || cmd_o == CMD_REF) |-> ($past(bank_act_o) == 2'b00)); // R8
  AST_RW_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> |($past(bank_act_o) & (2'b01 << bank_o))); // R7
  AST_ERR_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(mode_o)); // R9
  AST_ERR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cmd_o == CMD_ILLEGAL && !auto_pre_o)); // R9
endmodule

// File: tb/test_sdram_cmd_decoder.sv
`timescale 1ns/100ps
module test_sdram_cmd_decoder;
  logic clk = 0, rst_ni = 0, cke_i = 1;
  logic cs_ni = 1, ras_ni = 1, cas_ni = 1, we_ni = 1;
  logic [11:0] addr_i = '0;
  logic [3:0] cmd_o;
  logic bank_o, auto_pre_o, err_o;
  logic [1:0] bank_act_o;
  logic [9:0] mode_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_cmd, m_bank, m_ap, m_err;
  bit m_act[2];
  int m_cnt[2];
  logic [9:0] m_mode;
  bit m_cke;

  always #2.5 clk = ~clk;

  sdram_cmd_decoder i_sdram_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .addr_i(addr_i), .cmd_o(cmd_o), .bank_o(bank_o),
    .auto_pre_o(auto_pre_o), .err_o(err_o), .bank_act_o(bank_act_o), .mode_o(mode_o)
  );

  task automatic compare(input string tag);
    logic [1:0] ea;
    ea = {m_act[1], m_act[0]};
    n_run++;
    if (cmd_o !== 4'(m_cmd) || bank_o !== 1'(m_bank) || auto_pre_o !== 1'(m_ap) ||
        err_o !== 1'(m_err) || bank_act_o !== ea || mode_o !== m_mode) begin
      n_fail++;
      $display("FAIL %s: got cmd=%0d bank=%0d ap=%0d err=%0d act=%b mode=%h exp cmd=%0d bank=%0d ap=%0d err=%0d act=%b mode=%h",
               tag, cmd_o, bank_o, auto_pre_o, err_o, bank_act_o, mode_o,
               m_cmd, m_bank, m_ap, m_err, ea, m_mode);
    end
  endtask

  function automatic int burst_len(input logic [2:0] c);
    if (c >= 3) return 8;
    return 1 << c;
  endfunction

  task automatic model(input bit cs, input bit r, input bit c, input bit w,
                       input logic [11:0] a, input bit ke);
    int raw, s;
    bit ok;
    s = a[11];
    ok = 1;
    if (cs) raw = 1;
    else if ({r, c, w} == 3'b000) raw = 3;
    else if ({r, c, w} == 3'b001) raw = 9;
    else if ({r, c, w} == 3'b010) raw = a[10] ? 6 : 5;
    else if ({r, c, w} == 3'b011) raw = 4;
    else if ({r, c, w} == 3'b100) raw = 7;
    else if ({r, c, w} == 3'b101) raw = 8;
    else if ({r, c, w} == 3'b111) raw = 2;
    else raw = 15;
    if (raw == 15) ok = 0;
    if (raw == 3 && (m_act[0] || m_act[1] || a[8:7] != 0)) ok = 0;
    if (raw == 9 && (m_act[0] || m_act[1])) ok = 0;
    if (raw == 4 && m_act[s]) ok = 0;
    if ((raw == 7 || raw == 8) && (!m_act[s] || m_cnt[s] != 0)) ok = 0;
    if (!m_cke) m_cmd = 0;
    else m_cmd = ok ? raw : 15;
    m_err = (m_cmd == 15);
    m_bank = (m_cmd == 4 || m_cmd == 5 || m_cmd == 7 || m_cmd == 8) ? s : 0;
    m_ap = (m_cmd == 7 || m_cmd == 8) ? a[10] : 0;
    for (int b = 0; b < 2; b++)
      if (m_cnt[b] != 0) begin
        if (m_cnt[b] == 1) m_act[b] = 0;
        m_cnt[b]--;
      end
    case (m_cmd)
      4: m_act[s] = 1;
      5: begin m_act[s] = 0; m_cnt[s] = 0; end
      6: begin m_act = '{0, 0}; m_cnt = '{0, 0}; end
      7, 8: if (a[10]) m_cnt[s] = burst_len(m_mode[2:0]);
      3: m_mode = a[9:0];
      default: ;
    endcase
    m_cke = ke;
  endtask

  task automatic step(input string tag, input bit cs, input bit r, input bit c,
                      input bit w, input logic [11:0] a, input bit ke = 1);
    cs_ni = cs; ras_ni = r; cas_ni = c; we_ni = w; addr_i = a; cke_i = ke;
    @(posedge clk);
    model(cs, r, c, w, a, ke);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic nop(input string tag); step(tag, 0, 1, 1, 1, 12'h000); endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_cmd = 0; m_bank = 0; m_ap = 0; m_err = 0; m_act = '{0, 0}; m_cnt = '{0, 0};
    m_mode = '0; m_cke = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_ni = 1;
    compare("R1 after release");
    nop("R2 first edge none");
    nop("R3 nop");
    step("R3 deselect", 1, 0, 0, 0, 12'h000);
    step("R8 mode load bl4", 0, 0, 0, 0, 12'h202);
    step("R9 mode A7 set", 0, 0, 0, 0, 12'h082);
    step("R9 mode A8 set", 0, 0, 0, 0, 12'h103);
    step("R4 act bank1", 0, 0, 1, 1, 12'h800);
    step("R5 act open bank", 0, 0, 1, 1, 12'h800);
    step("R8 mode while open", 0, 0, 0, 0, 12'h001);
    step("R8 refresh while open", 0, 0, 0, 1, 12'h000);
    step("R7 read bank1", 0, 1, 0, 1, 12'h855);
    step("R7 write closed bank0", 0, 1, 0, 0, 12'h000);
    step("R4 act bank0", 0, 0, 1, 1, 12'h012);
    step("R9 reserved pattern", 0, 1, 1, 0, 12'h800);
    step("R7 write bank0", 0, 1, 0, 0, 12'h003);
    step("R6 pre bank0", 0, 0, 1, 0, 12'h000);
    step("R6 pre all", 0, 0, 1, 0, 12'h400);
    step("R8 refresh idle", 0, 0, 0, 1, 12'h000);
    step("R5 act bank1", 0, 0, 1, 1, 12'h800);
    step("R10 read ap bl4", 0, 1, 0, 1, 12'hC00);
    step("R10 read during countdown", 0, 1, 0, 1, 12'h800);
    step("R10 act during countdown", 0, 0, 1, 1, 12'h800);
    nop("R10 countdown");
    nop("R10 closed at 4th edge");
    nop("R10 stays closed");
    step("R2 cke low act executes", 0, 0, 1, 1, 12'h000, 0);
    step("R2 cke was low", 0, 0, 1, 1, 12'h800, 1);
    nop("R2 nop after resume");
    step("R6 pre all again", 0, 0, 1, 0, 12'h400);
    step("R8 mode bl1", 0, 0, 0, 0, 12'h000);
    step("R5 act bank0", 0, 0, 1, 1, 12'h000);
    step("R10 write ap bl1", 0, 1, 0, 0, 12'h400);
    nop("R10 bl1 closed");
    step("R8 mode bl8", 0, 0, 0, 0, 12'h006);
    step("R5 act bank0 b", 0, 0, 1, 1, 12'h000);
    step("R10 write ap bl8", 0, 1, 0, 0, 12'h400);
    nop("R10 bl8 counting");
    step("R10 pre cancels countdown", 0, 0, 1, 0, 12'h000);
    repeat (9) nop("R10 stays closed after pre");
    step("R5 reopen bank0", 0, 0, 1, 1, 12'h000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule